// File: doc/BRIEF.md
# Dual-Address Two-Wire Port Slave

This block is the serial slave front end of a sixteen-port expander. The ports form two banks of eight, and each bank has its own 7-bit bus address. Bank A holds mixed output and I/O ports. Bank B holds eight plain outputs. The block oversamples the bus clock and data lines with a fast system clock. It finds START, STOP and the acknowledge slot, and it pulls the data line low through an open-drain enable. The low four address bits come from an external address-pin decoder.

A write to either bank stores each received byte in that bank's output latch. A read of bank B returns the levels seen on its pins. A read of bank A returns a port byte and a transition-flag byte in turn, for as long as the master acknowledges. Port data is sampled again on every acknowledge that comes before a port byte. Single-cycle pulses tell the neighbouring interrupt logic when a bank A address or data byte has been acknowledged, and when a STOP has been seen.

Top module: `dual_addr_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte by holding SDA low through the ninth clock only when the 7-bit address equals prefix 110 (bank A) or prefix 101 (bank B), followed by `addr_lo[3:0]`. Bit 0 of the address byte is R/W, where 1 means read. Any other address is not acknowledged and changes no latch.
- R2: Each data byte written to bank A is acknowledged, and the acknowledge loads all eight bits into `a_out`. Later bytes in the same transaction overwrite it. `b_out` is unchanged.
- R3: Each data byte written to bank B is acknowledged and loads `b_out`. `a_out` is unchanged.
- R4: A bank A read returns the `a_pins` value sampled on the address acknowledge, then `a_flags`, then alternates port and flag bytes while the master acknowledges. Each port byte is sampled on the master acknowledge just before it, and each flag byte is taken on the acknowledge just before it. Bits are sent MSB first, and SDA changes only while SCL is low.
- R5: A bank B read returns the levels of `b_pins`, not `b_out`. The pins are sampled again on every acknowledge, so each byte is fresh.
- R6: A master NACK ends the read. The slave releases SDA and drives nothing more until STOP or a repeated START.
- R7: A repeated START begins a new address phase without an intervening STOP.
- R8: Driving `abort_n` low aborts any transaction. SDA is released within three clock cycles, both latches keep their values, and the next transaction works normally.
- R9: `a_addr_ack_p` pulses once for each acknowledged bank A address. `a_data_ack_p` pulses once for each bank A data acknowledge, whether the slave acknowledges a written byte or the master acknowledges a read byte. `stop_p` pulses once for each STOP.
- R10: After `rst_n` is released, `a_out` equals INIT_A (default 0xFF), `b_out` equals INIT_B (default 0x00), and `sda_oe` and all pulses are 0.
- R11: `sda_oe` only asserts while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| abort_n | input | 1 | Active-low bus abort; returns the slave to idle |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_lo | input | 4 | Low address bits from the pin decoder |
| a_pins | input | 8 | Bank A pin levels, MSB first: O7, O6, P5, P4, P3, P2, O1, O0 |
| a_flags | input | 8 | Bank A transition-flag byte |
| b_pins | input | 8 | Bank B pin levels |
| a_out | output | 8 | Bank A output latch |
| b_out | output | 8 | Bank B output latch |
| a_addr_ack_p | output | 1 | Pulse on a bank A address acknowledge |
| a_data_ack_p | output | 1 | Pulse on a bank A data acknowledge |
| stop_p | output | 1 | Pulse on STOP |

## Verification
A bit counter or state register that drifts by one shows up within a single byte. The ninth-clock acknowledge either goes missing or moves into a data bit, and a read byte comes back rotated. If the bank A toggle is wrong, the first port byte and flag byte swap, and this is visible on the second byte read. If the slave samples the pins at the wrong moment, a value the bench changes between bytes arrives one byte late. If the slave fails to release SDA after a NACK or an abort, the bus reads 0 bits on the very next byte.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_WAIT
    } st_e;

    typedef enum logic { BANK_A, BANK_B } bank_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        st_e               st;
        bank_e             bank;
        logic              rw;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic              flag_next;
        logic              oe;
        logic [BYTE_W-1:0] lat_a;
        logic [BYTE_W-1:0] lat_b;
        logic              p_addr;
        logic              p_data;
        logic              p_stop;
    } eng_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
    parameter int N       = 3,
    parameter int STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], din[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign dout[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2cx_bus_cond.sv
module i2cx_bus_cond
    import i2cx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_s,
    input  logic    sda_s,
    output bus_ev_t ev
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d       = scl_s;
        sda_d       = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end
endmodule

// File: rtl/i2cx_engine.sv
module i2cx_engine
    import i2cx_pkg::*;
#(
    parameter logic [2:0]        PFX_A  = 3'b110,
    parameter logic [2:0]        PFX_B  = 3'b101,
    parameter logic [BYTE_W-1:0] INIT_A = 8'hFF,
    parameter logic [BYTE_W-1:0] INIT_B = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_s_n,
    input  logic              sda_s,
    input  bus_ev_t           ev,
    input  logic [3:0]        addr_lo,
    input  logic [BYTE_W-1:0] a_pins,
    input  logic [BYTE_W-1:0] a_flags,
    input  logic [BYTE_W-1:0] b_pins,
    output eng_t              q
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    eng_t d;
    logic [6:0] addr7;
    logic       hit_a, hit_b;

    always_comb begin
        addr7 = q.sh[BYTE_W-1:1];
        hit_a = (addr7 == {PFX_A, addr_lo});
        hit_b = (addr7 == {PFX_B, addr_lo});

        d        = q;
        d.p_addr = 1'b0;
        d.p_data = 1'b0;
        d.p_stop = 1'b0;

        if (!abort_s_n) begin
            d.st  = ST_IDLE;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else if (ev.stop) begin
            d.st     = ST_IDLE;
            d.oe     = 1'b0;
            d.p_stop = 1'b1;
        end else if (ev.start) begin
            d.st  = ST_ADDR;
            d.oe  = 1'b0;
            d.cnt = '0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (ev.scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (ev.scl_fall && q.cnt == LAST_BIT) begin
                        d.cnt = '0;
                        if (hit_a || hit_b) begin
                            d.st   = ST_ADDR_ACK;
                            d.oe   = 1'b1;
                            d.bank = hit_a ? BANK_A : BANK_B;
                            d.rw   = q.sh[0];
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_rise) begin
                        d.p_addr = (q.bank == BANK_A);
                        if (q.rw) begin
                            d.tx        = (q.bank == BANK_A) ? a_pins : b_pins;
                            d.flag_next = 1'b1;
                        end
                    end else if (ev.scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RD;
                            d.oe = ~q.tx[BYTE_W-1];
                        end else begin
                            d.st = ST_WR;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WR: begin
                    if (ev.scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (ev.scl_fall && q.cnt == LAST_BIT) begin
                        d.st  = ST_WR_ACK;
                        d.oe  = 1'b1;
                        d.cnt = '0;
                        if (q.bank == BANK_A) begin
                            d.lat_a  = q.sh;
                            d.p_data = 1'b1;
                        end else begin
                            d.lat_b = q.sh;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (ev.scl_fall) begin
                        d.st  = ST_WR;
                        d.oe  = 1'b0;
                        d.cnt = '0;
                    end
                end
                ST_RD: begin
                    if (ev.scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (q.cnt == LAST_BIT) begin
                            d.st  = ST_RD_ACK;
                            d.oe  = 1'b0;
                            d.cnt = '0;
                        end else begin
                            d.oe = ~q.tx[BYTE_W-2];
                            d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        if (sda_s) begin
                            d.st = ST_WAIT;
                        end else if (q.bank == BANK_A) begin
                            d.p_data    = 1'b1;
                            d.tx        = q.flag_next ? a_flags : a_pins;
                            d.flag_next = ~q.flag_next;
                        end else begin
                            d.tx = b_pins;
                        end
                    end else if (ev.scl_fall) begin
                        d.st  = ST_RD;
                        d.oe  = ~q.tx[BYTE_W-1];
                        d.cnt = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.st        <= ST_IDLE;
            q.bank      <= BANK_A;
            q.lat_a     <= INIT_A;
            q.lat_b     <= INIT_B;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dual_addr_i2c_slave.sv
module dual_addr_i2c_slave
    import i2cx_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [2:0]  PFX_A       = 3'b110,
    parameter logic [2:0]  PFX_B       = 3'b101,
    parameter logic [7:0]  INIT_A      = 8'hFF,
    parameter logic [7:0]  INIT_B      = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [3:0] addr_lo,
    input  logic [7:0] a_pins,
    input  logic [7:0] a_flags,
    input  logic [7:0] b_pins,
    output logic [7:0] a_out,
    output logic [7:0] b_out,
    output logic       a_addr_ack_p,
    output logic       a_data_ack_p,
    output logic       stop_p
);
    logic [2:0] raw_in, syn_out;
    bus_ev_t    ev;
    eng_t       eng_q;

    assign raw_in = {abort_n, sda_i, scl_i};

    i2cx_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in), .dout(syn_out)
    );

    i2cx_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_s(syn_out[0]), .sda_s(syn_out[1]), .ev(ev)
    );

    i2cx_engine #(.PFX_A(PFX_A), .PFX_B(PFX_B), .INIT_A(INIT_A), .INIT_B(INIT_B)) u_eng (
        .clk(clk), .rst_n(rst_n), .abort_s_n(syn_out[2]), .sda_s(syn_out[1]), .ev(ev),
        .addr_lo(addr_lo), .a_pins(a_pins), .a_flags(a_flags), .b_pins(b_pins), .q(eng_q)
    );

    assign sda_oe       = eng_q.oe;
    assign a_out        = eng_q.lat_a;
    assign b_out        = eng_q.lat_b;
    assign a_addr_ack_p = eng_q.p_addr;
    assign a_data_ack_p = eng_q.p_data;
    assign stop_p       = eng_q.p_stop;
endmodule

// File: rtl/i2cx_checker.sv
module i2cx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       abort_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic [7:0] a_out,
    input logic [7:0] b_out,
    input logic       a_addr_ack_p,
    input logic       a_data_ack_p,
    input logic       stop_p
);
    // R11: drive only starts while the clock line is low
    a_r11_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    // R2: bank A latch only moves together with the slave acknowledge
    a_r2_latch_a_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_out) |-> sda_oe);

    // R3: bank B latch only moves together with the slave acknowledge
    a_r3_latch_b_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(b_out) |-> sda_oe);

    // R8: a held abort releases the data line
    a_r8_abort_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(abort_n, 2) && !$past(abort_n) && !abort_n) |=> !sda_oe);

    // R9: pulses last one cycle
    a_r9_addr_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        a_addr_ack_p |=> !a_addr_ack_p);
    a_r9_stop_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !stop_p);
    a_r9_data_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        a_data_ack_p |=> !a_data_ack_p);
endmodule

bind dual_addr_i2c_slave i2cx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .a_out(a_out), .b_out(b_out), .a_addr_ack_p(a_addr_ack_p),
    .a_data_ack_p(a_data_ack_p), .stop_p(stop_p)
);

// File: tb/dual_addr_i2c_slave_test.sv
module dual_addr_i2c_slave_test;
    localparam int Q = 6;
    localparam int WDOG = 100000;

    logic clk = 1'b0, rst_n = 1'b0, abort_n = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, sda_bus;
    logic [3:0] addr_lo = 4'h5;
    logic [7:0] a_pins = 8'h00, a_flags = 8'h00, b_pins = 8'h00;
    logic [7:0] a_out, b_out;
    logic a_addr_ack_p, a_data_ack_p, stop_p;

    int checks = 0, fails = 0;
    int n_addr = 0, n_data = 0, n_stop = 0, r11_viol = 0, cyc = 0;
    logic oe_prev = 1'b0;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    dual_addr_i2c_slave uut (
        .clk(clk), .rst_n(rst_n), .abort_n(abort_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .addr_lo(addr_lo), .a_pins(a_pins), .a_flags(a_flags),
        .b_pins(b_pins), .a_out(a_out), .b_out(b_out), .a_addr_ack_p(a_addr_ack_p),
        .a_data_ack_p(a_data_ack_p), .stop_p(stop_p)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (a_addr_ack_p) n_addr <= n_addr + 1;
        if (a_data_ack_p) n_data <= n_data + 1;
        if (stop_p)       n_stop <= n_stop + 1;
        if (rst_n && sda_oe && !oe_prev && scl_m) r11_viol <= r11_viol + 1;
        oe_prev <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = ~sda_bus; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq(Q);
            scl_m = 1'b1; wq(Q);
            v[i] = sda_bus; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        send_bit(~mack);
    endtask

    // {addr7, data, expect_ack, expect a_out, expect b_out}, addr_lo = 5
    localparam logic [31:0] WR_VEC [6] = '{
        {7'h65, 8'hA5, 1'b1, 8'hA5, 8'h00},
        {7'h55, 8'h3C, 1'b1, 8'hA5, 8'h3C},
        {7'h64, 8'hFF, 1'b0, 8'hA5, 8'h3C},
        {7'h45, 8'h00, 1'b0, 8'hA5, 8'h3C},
        {7'h65, 8'h0F, 1'b1, 8'h0F, 8'h3C},
        {7'h75, 8'h11, 1'b0, 8'h0F, 8'h3C}
    };

    initial begin : watchdog
        wait (cyc >= WDOG);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic ak;
        logic [7:0] rd;
        int a0, d0, s0;

        wq(4);
        rst_n = 1'b1;
        wq(4);
        chk("R10 a_out init", a_out, 8'hFF);
        chk("R10 b_out init", b_out, 8'h00);
        chk("R10 sda_oe init", sda_oe, 1'b0);
        chk("R10 pulses idle", {a_addr_ack_p, a_data_ack_p, stop_p}, 3'b000);

        a0 = n_addr; d0 = n_data; s0 = n_stop;
        for (int i = 0; i < 6; i++) begin
            i2c_start;
            write_byte({WR_VEC[i][31:25], 1'b0}, ak);
            chk("R1 address ack", ak, WR_VEC[i][16]);
            write_byte(WR_VEC[i][24:17], ak);
            chk("R2/R3 data ack", ak, WR_VEC[i][16]);
            i2c_stop;
            wq(4);
            chk("R2 a_out after vector", a_out, WR_VEC[i][15:8]);
            chk("R3 b_out after vector", b_out, WR_VEC[i][7:0]);
        end
        chk("R9 addr pulses", n_addr - a0, 2);
        chk("R9 data pulses", n_data - d0, 2);
        chk("R9 stop pulses", n_stop - s0, 6);

        // R2: multi-byte write overwrites
        i2c_start;
        write_byte(8'hCA, ak);
        write_byte(8'h11, ak);
        chk("R2 first byte latched", a_out, 8'h11);
        write_byte(8'h22, ak);
        i2c_stop; wq(4);
        chk("R2 second byte overwrites", a_out, 8'h22);
        chk("R2 b_out untouched", b_out, 8'h3C);

        // R7: repeated start
        i2c_start;
        write_byte(8'hCA, ak);
        write_byte(8'h77, ak);
        i2c_start;
        write_byte(8'hAA, ak);
        chk("R7 ack after repeated start", ak, 1'b1);
        write_byte(8'h88, ak);
        i2c_stop; wq(4);
        chk("R7 a_out", a_out, 8'h77);
        chk("R7 b_out", b_out, 8'h88);

        // R5: bank B read returns pins, resampled each ack
        b_pins = 8'h5A;
        i2c_start;
        write_byte(8'hAB, ak);
        b_pins = 8'hC3;
        read_byte(1'b1, rd);
        chk("R5 first byte from pins", rd, 8'h5A);
        read_byte(1'b0, rd);
        chk("R5 second byte fresh", rd, 8'hC3);
        i2c_stop; wq(4);
        chk("R5 latch not returned", b_out, 8'h88);

        // R4: bank A alternating read
        a_pins = 8'h96; a_flags = 8'h05;
        a0 = n_addr; d0 = n_data;
        i2c_start;
        write_byte(8'hCB, ak);
        a_pins = 8'h69; a_flags = 8'h0A;
        read_byte(1'b1, rd);
        chk("R4 byte1 port", rd, 8'h96);
        read_byte(1'b1, rd);
        chk("R4 byte2 flags", rd, 8'h0A);
        a_flags = 8'h03;
        read_byte(1'b1, rd);
        chk("R4 byte3 port resampled", rd, 8'h69);
        read_byte(1'b0, rd);
        chk("R4 byte4 flags", rd, 8'h03);
        i2c_stop; wq(4);
        chk("R9 read addr pulse", n_addr - a0, 1);
        chk("R9 read data pulses", n_data - d0, 3);

        // R6: NACK releases the line
        b_pins = 8'h00;
        i2c_start;
        write_byte(8'hAB, ak);
        read_byte(1'b0, rd);
        chk("R6 byte before nack", rd, 8'h00);
        read_byte(1'b0, rd);
        chk("R6 line released after nack", rd, 8'hFF);
        i2c_stop; wq(4);
        chk("R6 sda_oe idle", sda_oe, 1'b0);

        // R8: abort mid-read
        i2c_start;
        write_byte(8'hAB, ak);
        chk("R8 slave driving before abort", sda_oe, 1'b1);
        abort_n = 1'b0; wq(4);
        abort_n = 1'b1; wq(4);
        chk("R8 released by abort", sda_oe, 1'b0);
        i2c_stop; wq(4);
        chk("R8 a_out kept", a_out, 8'h77);
        chk("R8 b_out kept", b_out, 8'h88);
        i2c_start;
        write_byte(8'hCA, ak);
        write_byte(8'h5E, ak);
        i2c_stop; wq(4);
        chk("R8 works after abort", a_out, 8'h5E);

        chk("R11 no drive start with SCL high", r11_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule